// File: doc/BRIEF.md
# Prioritized Hardware Interrupt Controller

This block sits beside a processor core and decides which of five hardware interrupt requests is taken. There is a non-maskable trap, three maskable requests that each jump to a fixed vector, and one general request whose service address is supplied by the interrupting device. Each request is qualified by its own kind of sensitivity. The trap needs a rising edge and then a held level. The highest maskable vectored request latches its rising edge. The other two vectored requests and the general request are sampled as plain levels.

The core pulses a sample strobe once per instruction, in the second T-state of its last machine cycle. On that clock the block ranks the qualified requests and registers the result. One cycle later a take pulse appears with the vector address. For the general request it appears with an acknowledge strobe instead. The core also drives enable and disable commands and a mask write, and reads back a status word that holds the masks, the pending state and the global enable.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the global enable is 0, all three masks are 1, the edge latches are clear, and take_o, inta_o and vectored_o are 0. With all request inputs low, status_o reads 7'b0000111.
- R2: Requests are ranked only on a clock where sample_i is 1. The result appears as a one-cycle pulse on take_o in the following cycle, and take_o is 0 in every other cycle.
- R3: The trap is taken when its input has risen at an earlier clock and is still high on the sample clock. Masks and the global enable do not affect it. If the input falls before the sample, the pending trap is dropped. Taking the trap leaves the global enable unchanged.
- R4: A rising edge on rst75_i sets a latch that stays set after the input falls. The latch is cleared when that source is taken, or by a mask write with mask_wdata_i[3]=1. A new edge on the same clock as a clear sets the latch again.
- R5: rst65_i, rst55_i and intr_i count only when they are high on the sample clock itself.
- R6: A mask write loads mask_wdata_i[2:0], where bit 2 masks rst75, bit 1 masks rst65 and bit 0 masks rst55; a 1 blocks the source. status_o is {enable, rst75 latch, rst65_i, rst55_i, mask[2:0]}, with the enable at bit 6.
- R7: When the global enable is 0, only the trap can be taken. en_cmd_i sets the enable and dis_cmd_i clears it. If both are given on the same clock, the disable wins.
- R8: When intr_i is taken, inta_o pulses together with take_o, vectored_o is 0 and vector_o is 16'h0000.
- R9: The priority from highest to lowest is trap, rst75, rst65, rst55, intr. The vectors are 16'h0024, 16'h003C, 16'h0034 and 16'h002C, and vectored_o is 1 for these four sources.
- R10: Taking any maskable source clears the global enable. This takes precedence over an en_cmd_i on the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_i | input | 1 | Interrupt sample strobe from the core |
| trap_i | input | 1 | Non-maskable edge-and-level request |
| rst75_i | input | 1 | Latched rising-edge vectored request |
| rst65_i | input | 1 | Level vectored request |
| rst55_i | input | 1 | Level vectored request, lowest vectored |
| intr_i | input | 1 | Level non-vectored request |
| en_cmd_i | input | 1 | Enable command |
| dis_cmd_i | input | 1 | Disable command |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 4 | Mask bits [2:0], rst75 latch clear [3] |
| status_o | output | 7 | Mask-read word |
| take_o | output | 1 | Interrupt accepted pulse |
| vector_o | output | 16 | Service vector address |
| vectored_o | output | 1 | Accepted source has a fixed vector |
| inta_o | output | 1 | Acknowledge strobe for the non-vectored source |

## Verification
The assertions check on every cycle that a take only follows a sample strobe, and that the acknowledge only comes with a non-vectored take. They also check that a taken trap had its input still high, that no maskable source is taken while the enable is off, and that a maskable take leaves the enable cleared. Only the bench scenarios can show the things that span many cycles: the exact priority and vector for each mix of requests, that the rst75 latch keeps a short pulse, and that a trap is dropped when its input falls before the sample. The same holds for the precedence of the commands, the mask write and its latch-clear bit, and the contents of the status word.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC   = 5;
    localparam int MASK_W = 3;
    localparam int VEC_W  = 16;
    localparam int STAT_W = 2 * MASK_W + 1;

    localparam int SRC_TRAP = 0;
    localparam int SRC_R75  = 1;
    localparam int SRC_R65  = 2;
    localparam int SRC_R55  = 3;
    localparam int SRC_INTR = 4;

    localparam logic [VEC_W-1:0] VEC_TRAP = 16'h0024;
    localparam logic [VEC_W-1:0] VEC_R75  = 16'h003C;
    localparam logic [VEC_W-1:0] VEC_R65  = 16'h0034;
    localparam logic [VEC_W-1:0] VEC_R55  = 16'h002C;

    typedef struct packed {
        logic              ie;
        logic [MASK_W-1:0] mask;
        logic              take;
        logic [VEC_W-1:0]  vec;
        logic              vecd;
        logic              inta;
    } ctl_state_t;

    function automatic logic [VEC_W-1:0] vec_of(input logic [NSRC-1:0] g);
        logic [VEC_W-1:0] v;
        v = '0;
        if (g[SRC_TRAP]) v = VEC_TRAP;
        if (g[SRC_R75])  v = VEC_R75;
        if (g[SRC_R65])  v = VEC_R65;
        if (g[SRC_R55])  v = VEC_R55;
        return v;
    endfunction
endpackage

// File: rtl/irq_edge_cap.sv
module irq_edge_cap #(
    parameter bit DROP_ON_LOW = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_i,
    input  logic clr_i,
    output logic pend_o
);
    typedef struct packed {
        logic prev;
        logic pend;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d      = cap_q;
        cap_d.prev = in_i;
        cap_d.pend = (cap_q.pend & ~clr_i) | (in_i & ~cap_q.prev);
        if (DROP_ON_LOW && !in_i) begin
            cap_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign pend_o = cap_q.pend;

    AST_EDGE_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_o) |-> $past(in_i)); // R4
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
    parameter int N = 5
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o
);
    logic found;

    always_comb begin
        grant_o = '0;
        found   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && !found) begin
                grant_o[i] = 1'b1;
                found      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_i,
    input  logic              trap_i,
    input  logic              rst75_i,
    input  logic              rst65_i,
    input  logic              rst55_i,
    input  logic              intr_i,
    input  logic              en_cmd_i,
    input  logic              dis_cmd_i,
    input  logic              mask_wr_i,
    input  logic [MASK_W:0]   mask_wdata_i,
    output logic [STAT_W-1:0] status_o,
    output logic              take_o,
    output logic [VEC_W-1:0]  vector_o,
    output logic              vectored_o,
    output logic              inta_o
);
    ctl_state_t st_d, st_q;

    logic            trap_pend, r75_pend;
    logic            trap_clr, r75_clr;
    logic [NSRC-1:0] req, grant, accept;

    irq_edge_cap #(.DROP_ON_LOW(1'b1)) u_trap_cap (
        .clk(clk), .rst_n(rst_n), .in_i(trap_i), .clr_i(trap_clr), .pend_o(trap_pend)
    );

    irq_edge_cap #(.DROP_ON_LOW(1'b0)) u_r75_cap (
        .clk(clk), .rst_n(rst_n), .in_i(rst75_i), .clr_i(r75_clr), .pend_o(r75_pend)
    );

    always_comb begin
        req           = '0;
        req[SRC_TRAP] = trap_pend & trap_i;
        req[SRC_R75]  = r75_pend & ~st_q.mask[2] & st_q.ie;
        req[SRC_R65]  = rst65_i  & ~st_q.mask[1] & st_q.ie;
        req[SRC_R55]  = rst55_i  & ~st_q.mask[0] & st_q.ie;
        req[SRC_INTR] = intr_i & st_q.ie;
    end

    irq_prio_arb #(.N(NSRC)) u_arb (
        .req_i(req), .grant_o(grant)
    );

    assign accept   = sample_i ? grant : '0;
    assign trap_clr = accept[SRC_TRAP];
    assign r75_clr  = accept[SRC_R75] | (mask_wr_i & mask_wdata_i[MASK_W]);

    always_comb begin
        st_d      = st_q;
        st_d.take = |accept;
        st_d.vec  = vec_of(accept);
        st_d.vecd = |accept[SRC_R55:SRC_TRAP];
        st_d.inta = accept[SRC_INTR];
        if (mask_wr_i) begin
            st_d.mask = mask_wdata_i[MASK_W-1:0];
        end
        if (en_cmd_i) begin
            st_d.ie = 1'b1;
        end
        if (dis_cmd_i) begin
            st_d.ie = 1'b0;
        end
        if (|accept[SRC_INTR:SRC_R75]) begin
            st_d.ie = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o   = {st_q.ie, r75_pend, rst65_i, rst55_i, st_q.mask};
    assign take_o     = st_q.take;
    assign vector_o   = st_q.vec;
    assign vectored_o = st_q.vecd;
    assign inta_o     = st_q.inta;

    AST_TAKE_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(sample_i)); // R2
    AST_INTA_NONVECTORED: assert property (@(posedge clk) disable iff (!rst_n)
        inta_o |-> (take_o && !vectored_o && vector_o == '0)); // R8
    AST_TRAP_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && vector_o == VEC_TRAP) |-> $past(trap_i)); // R3
    AST_DISABLED_ONLY_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && !st_q.ie && !req[SRC_TRAP]) |=> !take_o); // R7
    AST_MASKABLE_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && vector_o != VEC_TRAP) |-> !st_q.ie); // R10
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample, trap, r75, r65, r55, intr, en, dis, mwr;
    logic [3:0]  mwd;
    logic [6:0]  status;
    logic        take, vecd, inta;
    logic [15:0] vec;

    int checks = 0;
    int failures = 0;

    // bench model state
    logic       m_ie, m_l75, m_p75, m_tprev, m_tpend;
    logic [2:0] m_mask;
    logic       e_take, e_vecd, e_inta;
    logic [15:0] e_vec;

    always #10 clk = ~clk;

    irq_prio_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .sample_i(sample), .trap_i(trap),
        .rst75_i(r75), .rst65_i(r65), .rst55_i(r55), .intr_i(intr),
        .en_cmd_i(en), .dis_cmd_i(dis), .mask_wr_i(mwr), .mask_wdata_i(mwd),
        .status_o(status), .take_o(take), .vector_o(vec),
        .vectored_o(vecd), .inta_o(inta)
    );

    function automatic int pick(input logic [4:0] c);
        for (int i = 0; i < 5; i++) if (c[i]) return i;
        return -1;
    endfunction

    function automatic logic [15:0] vec_for(input int s);
        case (s)
            0: return 16'h0024;
            1: return 16'h003C;
            2: return 16'h0034;
            3: return 16'h002C;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic idle_inputs();
        sample = 0; trap = 0; r75 = 0; r65 = 0; r55 = 0; intr = 0;
        en = 0; dis = 0; mwr = 0; mwd = 0;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a falling edge with inputs already set; ends at the next falling edge.
    task automatic cyc(input string tag);
        logic [4:0] c;
        int w;
        #1;
        check({tag, " status"}, {25'd0, status}, {25'd0, m_ie, m_l75, r65, r55, m_mask});
        c[0] = m_tpend & trap;
        c[1] = m_l75 & ~m_mask[2] & m_ie;
        c[2] = r65 & ~m_mask[1] & m_ie;
        c[3] = r55 & ~m_mask[0] & m_ie;
        c[4] = intr & m_ie;
        w = sample ? pick(c) : -1;
        e_take = (w >= 0);
        e_vec  = vec_for(w);
        e_vecd = (w >= 0 && w < 4);
        e_inta = (w == 4);
        @(posedge clk);
        m_tpend = trap ? ((m_tpend & ~(w == 0)) | ~m_tprev) : 1'b0;
        m_tprev = trap;
        m_l75   = (m_l75 & ~((w == 1) | (mwr & mwd[3]))) | (r75 & ~m_p75);
        m_p75   = r75;
        if (mwr) m_mask = mwd[2:0];
        if (en) m_ie = 1'b1;
        if (dis) m_ie = 1'b0;
        if (w >= 1) m_ie = 1'b0;
        @(negedge clk);
        check({tag, " out"}, {13'd0, take, vec, vecd, inta}, {13'd0, e_take, e_vec, e_vecd, e_inta});
    endtask

    task automatic hold(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h1234_5a5a;
        void'($urandom(seed));
        idle_inputs();
        m_ie = 0; m_l75 = 0; m_p75 = 0; m_tprev = 0; m_tpend = 0; m_mask = 3'b111;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 status", {25'd0, status}, 32'h07);
        check("R1 out", {13'd0, take, vec, vecd, inta}, 32'd0);
        hold(2, "R1");

        // R3: trap while disabled and masked
        trap = 1; hold(2, "R3");
        sample = 1; cyc("R3"); sample = 0; hold(1, "R3");
        // R3: trap drops when input falls before the sample
        trap = 0; hold(1, "R3");
        trap = 1; hold(2, "R3"); trap = 0; hold(1, "R3");
        sample = 1; cyc("R3"); sample = 0;
        // R7: enable and disable together, disable wins
        en = 1; dis = 1; cyc("R7"); en = 0; dis = 0;
        r65 = 1; mwr = 1; mwd = 4'b0000; cyc("R6"); mwr = 0;
        sample = 1; cyc("R7"); sample = 0;
        // R4: short pulse on rst75 latched, then taken
        en = 1; cyc("R7"); en = 0; r65 = 0;
        r75 = 1; cyc("R4"); r75 = 0; hold(3, "R4");
        sample = 1; cyc("R4"); sample = 0;
        // R10: enable cleared after maskable take; en on the same clock loses
        hold(1, "R10");
        en = 1; cyc("R10"); en = 0;
        r75 = 1; cyc("R4"); r75 = 0;
        sample = 1; en = 1; cyc("R10"); sample = 0; en = 0;
        hold(1, "R10");
        // R4: latch cleared by mask write bit 3
        r75 = 1; cyc("R4"); r75 = 0;
        mwr = 1; mwd = 4'b1000; cyc("R4"); mwr = 0;
        en = 1; cyc("R4"); en = 0;
        sample = 1; cyc("R4"); sample = 0;
        // R5: level released before the sample counts for nothing
        r55 = 1; hold(2, "R5"); r55 = 0;
        sample = 1; cyc("R5"); sample = 0;
        // R8: non-vectored request
        intr = 1; sample = 1; cyc("R8"); sample = 0; intr = 0;
        // R9: all at once, then descending
        en = 1; cyc("R9"); en = 0;
        trap = 1; r75 = 1; r65 = 1; r55 = 1; intr = 1; hold(2, "R9");
        sample = 1; cyc("R9"); sample = 0; trap = 0;
        for (int k = 0; k < 4; k++) begin
            en = 1; cyc("R9"); en = 0;
            sample = 1; cyc("R9"); sample = 0;
        end
        idle_inputs(); hold(1, "R9");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            sample = ($urandom % 3) == 0;
            if (($urandom % 8) == 0) trap = ~trap;
            r75  = ($urandom % 4) == 0;
            r65  = ($urandom % 3) == 0;
            r55  = ($urandom % 3) == 0;
            intr = ($urandom % 3) == 0;
            en   = ($urandom % 4) == 0;
            dis  = ($urandom % 16) == 0;
            mwr  = ($urandom % 10) == 0;
            mwd  = 4'($urandom);
            cyc("R2");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule